// File: doc/BRIEF.md
# Lockable Cache Line State Manager

This block holds the bookkeeping state of a small set-associative cache. For every set and way it keeps a tag, a valid bit, a dirty bit and a lock bit. A control agent issues maintenance commands to it one at a time. Each command names a single line, in one of two ways. In the hit form the block looks up an address. In the indexed form the caller picks a set (from the index bits of the address) and a way directly, whatever tag that line holds.

The block supports six commands: invalidate, writeback, writeback-and-invalidate, prefetch-and-lock, unlock, and a whole-cache reset. Lock bits change what each command does. A locked line survives invalidation, but it is still written back when dirty. Prefetch-and-lock on a miss first takes a victim way, writing the victim back if it is dirty. It then fetches the requested line and pins it. Dirty writebacks and fills share one request/acknowledge memory port that carries only the line address and a direction bit.

A store path elsewhere marks lines dirty through a mark input. A combinational probe port reports the hit, dirty and lock state of any address. Setting the parameter `WB_EN` to 0 gives the instruction-cache variant, which has no dirty state and never writes back.

Top module: `clsm_line_state`

FSM states and transitions:
- IDLE: waits for a command. On `cmd_valid` it latches the target line and moves to APPLY, or to UNLK_ALL for the reset command.
- APPLY: applies the command.
  - It moves to WB when a dirty target or dirty victim must be written.
  - It moves to FILL on a lock miss with a clean or invalid victim.
  - In every other case it returns to IDLE.
- WB: holds the write request. On acknowledge it goes to FILL for a lock command and to IDLE for all other commands.
- FILL: holds the read request. On acknowledge it goes to IDLE.
- UNLK_ALL: clears the lock bits of one set per cycle. After the last set it moves to INV_ALL.
- INV_ALL: clears the valid and dirty bits of one set per cycle. After the last set it moves to IDLE.

## Requirements
- R1: Invalidate (`cmd_op`=0) on a valid line clears its valid and dirty bits, unless the line's lock bit is set. A locked line stays valid.
- R2: Writeback (`cmd_op`=1) on a valid dirty line raises exactly one request with `mem_write`=1 and `mem_addr` = {stored tag, set, zero offset}. After the acknowledge the line is clean and still valid. A clean line causes no request.
- R3: Writeback-and-invalidate (`cmd_op`=2) writes back a dirty line as in R2. It then invalidates the line whether it was dirty or clean, unless the line is locked. A locked line ends clean and valid.
- R4: Prefetch-and-lock (`cmd_op`=3, always hit form) on a hit only sets the lock bit and makes no memory request. On a miss it raises one request with `mem_write`=0 at the line address. After the acknowledge the line is valid, clean and locked.
- R5: On a lock miss, the victim is the lowest-numbered invalid way, or if there is none, the lowest-numbered unlocked way. A dirty victim is written back before the fill.
- R6: If a lock miss finds every way of the set locked, `err` pulses for one cycle. No request is made and no state changes.
- R7: Unlock (`cmd_op`=4) clears the lock bit of the target line. A line that is not locked keeps its valid and dirty bits unchanged.
- R8: Reset (`cmd_op`=5) first clears every lock bit and then clears every valid and dirty bit. It makes no memory request, and afterwards every address misses.
- R9: `busy` is high from the cycle after acceptance until the last acknowledge of that command. A command presented while `busy` is high is ignored. `sync_done` is high only while `sync_req` is high and the block is idle.
- R10: Hit-form commands and the mark and probe ports ignore the address bits below the line offset.
- R11: Indexed form (`cmd_indexed`=1, all commands except lock) acts on set = index bits of `cmd_addr` and way = `cmd_way`, whatever tag that line holds.
- R12: With `WB_EN`=0, marking has no effect, lines never read dirty, writeback commands make no request, and writeback-and-invalidate acts as invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 3 | Command code (0 inv, 1 wb, 2 wb+inv, 3 lock, 4 unlock, 5 reset) |
| cmd_indexed | input | 1 | 1 selects the indexed form |
| cmd_addr | input | ADDR_W | Command address (tag, index, offset) |
| cmd_way | input | WAY_W | Way for the indexed form |
| busy | output | 1 | Command in progress |
| err | output | 1 | One-cycle pulse: lock miss with every way locked |
| sync_req | input | 1 | Synchronisation request |
| sync_done | output | 1 | Synchronisation complete (idle) |
| mark_valid | input | 1 | Store path marks a line dirty |
| mark_addr | input | ADDR_W | Address to mark |
| look_addr | input | ADDR_W | Probe address |
| look_hit | output | 1 | Probe address is cached |
| look_dirty | output | 1 | Probed line is dirty |
| look_locked | output | 1 | Probed line is locked |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_write | output | 1 | 1 writeback, 0 fill |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
The bench targets these corner cases:
- Invalidation and writeback-and-invalidate aimed at locked lines. A design that ignores the lock loses a pinned line.
- A lock miss whose victim is dirty. A design that skips the writeback silently drops modified data.
- A set whose ways are all locked. A design that does not guard this case overwrites a pinned line instead of pulsing `err`.
- Commands presented while `busy`, indexed operations on lines holding a foreign tag, and addresses with nonzero offset bits. Each of these shows up as a wrong line being touched.
- The reset command against locked, dirty lines. Doing the two passes in the wrong order, or applying the lock rule during the reset, leaves lines valid.
- The no-writeback variant. Failing to disable it produces stray write requests or dirty lines.

// File: rtl/clsm_pkg.sv
package clsm_pkg;
    typedef enum logic [2:0] {
        OP_INV    = 3'd0,
        OP_WB     = 3'd1,
        OP_WBI    = 3'd2,
        OP_LOCK   = 3'd3,
        OP_UNLOCK = 3'd4,
        OP_RESET  = 3'd5
    } clsm_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_APPLY,
        ST_WB,
        ST_FILL,
        ST_UNLK_ALL,
        ST_INV_ALL
    } clsm_state_e;
endpackage

// File: rtl/clsm_tag_match.sv
module clsm_tag_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 6,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]  valid,
    input  logic [TAG_W-1:0] tags [WAYS],
    input  logic [TAG_W-1:0] tag,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w] == tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/clsm_victim_pick.sv
module clsm_victim_pick #(
    parameter int WAYS = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]  valid,
    input  logic [WAYS-1:0]  locked,
    output logic             found,
    output logic [WAY_W-1:0] way
);
    logic [WAY_W-1:0] free_way, unl_way;

    always_comb begin
        free_way = '0;
        unl_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w])  free_way = WAY_W'(w);
            if (!locked[w]) unl_way  = WAY_W'(w);
        end
    end

    assign found = ~&locked;
    assign way   = (~&valid) ? free_way : unl_way;
endmodule

// File: rtl/clsm_line_state.sv
module clsm_line_state
    import clsm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OFF_W  = 4,
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter bit WB_EN  = 1'b1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              cmd_indexed,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [WAY_W-1:0]  cmd_way,
    output logic              busy,
    output logic              err,
    input  logic              sync_req,
    output logic              sync_done,
    input  logic              mark_valid,
    input  logic [ADDR_W-1:0] mark_addr,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_hit,
    output logic              look_dirty,
    output logic              look_locked,
    output logic              mem_req,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack
);
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - OFF_W - SET_W;

    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];
    logic [WAYS-1:0]  lock_q  [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];

    clsm_state_e      state_q, state_d;
    clsm_op_e         op_q;
    logic [SET_W-1:0] set_q, cnt_q;
    logic [TAG_W-1:0] ctag_q;
    logic [WAY_W-1:0] way_q;
    logic             hit_q;

    // address fields
    wire [SET_W-1:0] c_set = cmd_addr[OFF_W +: SET_W];
    wire [TAG_W-1:0] c_tag = cmd_addr[ADDR_W-1 -: TAG_W];
    wire [SET_W-1:0] m_set = mark_addr[OFF_W +: SET_W];
    wire [SET_W-1:0] l_set = look_addr[OFF_W +: SET_W];

    logic             c_hit, m_hit, l_hit, v_found;
    logic [WAY_W-1:0] c_way, m_way, l_way, v_way;

    clsm_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmd_match (
        .valid(valid_q[c_set]), .tags(tag_q[c_set]), .tag(c_tag),
        .hit(c_hit), .hit_way(c_way));
    clsm_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_mark_match (
        .valid(valid_q[m_set]), .tags(tag_q[m_set]),
        .tag(mark_addr[ADDR_W-1 -: TAG_W]), .hit(m_hit), .hit_way(m_way));
    clsm_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_look_match (
        .valid(valid_q[l_set]), .tags(tag_q[l_set]),
        .tag(look_addr[ADDR_W-1 -: TAG_W]), .hit(l_hit), .hit_way(l_way));
    clsm_victim_pick #(.WAYS(WAYS)) u_victim (
        .valid(valid_q[set_q]), .locked(lock_q[set_q]),
        .found(v_found), .way(v_way));

    wire t_dirty = hit_q && dirty_q[set_q][way_q];
    wire t_lock  = hit_q && lock_q[set_q][way_q];
    wire v_dirty = valid_q[set_q][v_way] && dirty_q[set_q][v_way];
    wire last    = (cnt_q == SET_W'(SETS - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (cmd_valid)
                    state_d = (clsm_op_e'(cmd_op) == OP_RESET) ? ST_UNLK_ALL : ST_APPLY;
            ST_APPLY: begin
                state_d = ST_IDLE;
                if ((op_q == OP_WB || op_q == OP_WBI) && WB_EN && t_dirty)
                    state_d = ST_WB;
                else if (op_q == OP_LOCK && !hit_q && v_found)
                    state_d = (WB_EN && v_dirty) ? ST_WB : ST_FILL;
            end
            ST_WB:       if (mem_ack) state_d = (op_q == OP_LOCK) ? ST_FILL : ST_IDLE;
            ST_FILL:     if (mem_ack) state_d = ST_IDLE;
            ST_UNLK_ALL: if (last) state_d = ST_INV_ALL;
            ST_INV_ALL:  if (last) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // line state and command registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                lock_q[s]  <= '0;
                for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
            end
            op_q <= OP_INV; set_q <= '0; cnt_q <= '0; ctag_q <= '0;
            way_q <= '0; hit_q <= 1'b0; err <= 1'b0;
        end else begin
            err <= 1'b0;
            if (WB_EN && mark_valid && m_hit) dirty_q[m_set][m_way] <= 1'b1;
            unique case (state_q)
                ST_IDLE: if (cmd_valid) begin
                    op_q   <= clsm_op_e'(cmd_op);
                    set_q  <= c_set;
                    ctag_q <= c_tag;
                    cnt_q  <= '0;
                    if (cmd_indexed && clsm_op_e'(cmd_op) != OP_LOCK) begin
                        way_q <= cmd_way;
                        hit_q <= valid_q[c_set][cmd_way];
                    end else begin
                        way_q <= c_way;
                        hit_q <= c_hit;
                    end
                end
                ST_APPLY: unique case (op_q)
                    OP_INV, OP_WBI:
                        if (hit_q && !t_lock && !(op_q == OP_WBI && WB_EN && t_dirty)) begin
                            valid_q[set_q][way_q] <= 1'b0;
                            dirty_q[set_q][way_q] <= 1'b0;
                        end
                    OP_LOCK:
                        if (hit_q) lock_q[set_q][way_q] <= 1'b1;
                        else if (!v_found) err <= 1'b1;
                        else way_q <= v_way;
                    OP_UNLOCK:
                        if (hit_q) lock_q[set_q][way_q] <= 1'b0;
                    default: ;
                endcase
                ST_WB: if (mem_ack) begin
                    dirty_q[set_q][way_q] <= 1'b0;
                    if (op_q == OP_WBI && !lock_q[set_q][way_q])
                        valid_q[set_q][way_q] <= 1'b0;
                end
                ST_FILL: if (mem_ack) begin
                    valid_q[set_q][way_q] <= 1'b1;
                    dirty_q[set_q][way_q] <= 1'b0;
                    lock_q[set_q][way_q]  <= 1'b1;
                    tag_q[set_q][way_q]   <= ctag_q;
                end
                ST_UNLK_ALL: begin
                    lock_q[cnt_q] <= '0;
                    cnt_q <= last ? '0 : cnt_q + 1'b1;
                end
                ST_INV_ALL: begin
                    valid_q[cnt_q] <= '0;
                    dirty_q[cnt_q] <= '0;
                    cnt_q <= cnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy        = (state_q != ST_IDLE);
        sync_done   = sync_req && (state_q == ST_IDLE);
        mem_req     = (state_q == ST_WB) || (state_q == ST_FILL);
        mem_write   = (state_q == ST_WB);
        mem_addr    = '0;
        if (state_q == ST_WB)
            mem_addr = {tag_q[set_q][way_q], set_q, {OFF_W{1'b0}}};
        else if (state_q == ST_FILL)
            mem_addr = {ctag_q, set_q, {OFF_W{1'b0}}};
        look_hit    = l_hit;
        look_dirty  = l_hit && dirty_q[l_set][l_way];
        look_locked = l_hit && lock_q[l_set][l_way];
    end

    // ---------------- assertions ----------------
    assert_locked_survives_inv_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_APPLY && op_q == OP_INV && hit_q && lock_q[set_q][way_q])
        |=> valid_q[$past(set_q)][$past(way_q)]);

    assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_write)));

    assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    assert_err_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !mem_req);

    for (genvar s = 0; s < SETS; s++) begin : g_chk
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            assert_lock_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
                lock_q[s][w] |-> valid_q[s][w]);
            assert_dirty_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
                dirty_q[s][w] |-> valid_q[s][w]);
        end
    end

    if (!WB_EN) begin : g_nowb
        assert_no_write_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
            !(mem_req && mem_write));
    end
endmodule

// File: tb/clsm_line_state_test.sv
module clsm_line_state_test;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          cmd_valid = 0, cmd_indexed = 0, sync_req = 0, mark_valid = 0, mem_ack = 0;
    logic [2:0]    cmd_op = 0;
    logic [AW-1:0] cmd_addr = 0, mark_addr = 0, look_addr = 0;
    logic [0:0]    cmd_way = 0;
    logic          busy, err, sync_done, look_hit, look_dirty, look_locked, mem_req, mem_write;
    logic [AW-1:0] mem_addr;

    clsm_line_state uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_indexed(cmd_indexed), .cmd_addr(cmd_addr), .cmd_way(cmd_way),
        .busy(busy), .err(err), .sync_req(sync_req), .sync_done(sync_done),
        .mark_valid(mark_valid), .mark_addr(mark_addr), .look_addr(look_addr),
        .look_hit(look_hit), .look_dirty(look_dirty), .look_locked(look_locked),
        .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr), .mem_ack(mem_ack));

    // instruction-cache variant
    logic          i_cv = 0, i_mv = 0, i_ack = 0;
    logic [2:0]    i_op = 0;
    logic [AW-1:0] i_addr = 0;
    logic          i_busy, i_err, i_sd, i_hit, i_dirty, i_lock, i_req, i_wr;
    logic [AW-1:0] i_maddr;
    int            i_wr_seen = 0;

    clsm_line_state #(.WB_EN(1'b0)) uut_ic (
        .clk(clk), .rst_n(rst_n), .cmd_valid(i_cv), .cmd_op(i_op),
        .cmd_indexed(1'b0), .cmd_addr(i_addr), .cmd_way(1'b0),
        .busy(i_busy), .err(i_err), .sync_req(1'b0), .sync_done(i_sd),
        .mark_valid(i_mv), .mark_addr(i_addr), .look_addr(i_addr),
        .look_hit(i_hit), .look_dirty(i_dirty), .look_locked(i_lock),
        .mem_req(i_req), .mem_write(i_wr), .mem_addr(i_maddr), .mem_ack(i_ack));

    int vectors = 0, miscompares = 0;
    int wr_seen = 0, rd_seen = 0, err_seen = 0, dly = 0;
    int exp_wr = 0, exp_rd = 0, exp_err = 0;
    logic [AW-1:0] last_wr = 0, last_rd = 0;

    // memory responder: acknowledge after three cycles
    always @(negedge clk) begin
        if (err) err_seen++;
        if (mem_ack) mem_ack = 0;
        else if (mem_req) begin
            dly++;
            if (dly == 3) begin
                dly = 0;
                mem_ack = 1;
                if (mem_write) begin wr_seen++; last_wr = mem_addr; end
                else begin rd_seen++; last_rd = mem_addr; end
            end
        end
        if (i_ack) i_ack = 0;
        else if (i_req) begin
            i_ack = 1;
            if (i_wr) i_wr_seen++;
        end
    end

    // reference model
    bit       mv [4][2], md [4][2], ml [4][2];
    bit [5:0] mt [4][2];

    function automatic int find(int s, bit [5:0] t);
        for (int w = 0; w < 2; w++) if (mv[s][w] && mt[s][w] == t) return w;
        return -1;
    endfunction

    function automatic void model_cmd(int op, bit idx, logic [AW-1:0] a, int way);
        int s = a[5:4];
        bit [5:0] t = a[11:6];
        int w;
        bit h;
        if (op == 5) begin
            for (int i = 0; i < 4; i++) for (int j = 0; j < 2; j++) begin
                mv[i][j] = 0; md[i][j] = 0; ml[i][j] = 0;
            end
            return;
        end
        if (idx && op != 3) begin w = way; h = mv[s][w]; end
        else begin w = find(s, t); h = (w >= 0); end
        case (op)
            0: if (h && !ml[s][w]) begin mv[s][w] = 0; md[s][w] = 0; end
            1: if (h && md[s][w]) begin exp_wr++; md[s][w] = 0; end
            2: if (h) begin
                   if (md[s][w]) begin exp_wr++; md[s][w] = 0; end
                   if (!ml[s][w]) mv[s][w] = 0;
               end
            3: if (h) ml[s][w] = 1;
               else begin
                   w = -1;
                   for (int j = 1; j >= 0; j--) if (!mv[s][j]) w = j;
                   if (w < 0) for (int j = 1; j >= 0; j--) if (!ml[s][j]) w = j;
                   if (w < 0) exp_err++;
                   else begin
                       if (mv[s][w] && md[s][w]) exp_wr++;
                       exp_rd++;
                       mv[s][w] = 1; md[s][w] = 0; ml[s][w] = 1; mt[s][w] = t;
                   end
               end
            4: if (h) ml[s][w] = 0;
            default: ;
        endcase
    endfunction

    function automatic string req_of(int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4/R5/R6";
            4: return "R7";
            5: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string req, int act, int expv);
        vectors++;
        if (act != expv) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // compare every pool address (offset bits nonzero, R10) and traffic counts
    task automatic check_all(string req);
        int bad = 0, act = 0, expv = 0;
        for (int t = 0; t < 4; t++) for (int s = 0; s < 4; s++) begin
            int w;
            look_addr = {6'(t), 2'(s), 4'hB};
            #1;
            w = find(s, 6'(t));
            if (!bad && ({look_hit, look_dirty, look_locked} !=
                {w >= 0, w >= 0 && md[s][w], w >= 0 && ml[s][w]})) begin
                bad = 1;
                act  = {look_hit, look_dirty, look_locked};
                expv = {w >= 0, w >= 0 && md[s][w], w >= 0 && ml[s][w]};
            end
        end
        if (!bad && (wr_seen != exp_wr || rd_seen != exp_rd || err_seen != exp_err)) begin
            bad = 1;
            act  = wr_seen * 10000 + rd_seen * 100 + err_seen;
            expv = exp_wr * 10000 + exp_rd * 100 + exp_err;
        end
        vectors++;
        if (bad) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic issue(int op, bit idx, logic [AW-1:0] a, int way);
        @(negedge clk);
        cmd_valid = 1; cmd_op = 3'(op); cmd_indexed = idx; cmd_addr = a; cmd_way = 1'(way);
        @(negedge clk);
        cmd_valid = 0;
        while (busy) @(negedge clk);
        @(negedge clk);
        model_cmd(op, idx, a, way);
    endtask

    task automatic mark(logic [AW-1:0] a);
        int w;
        @(negedge clk);
        mark_valid = 1; mark_addr = a;
        @(negedge clk);
        mark_valid = 0;
        w = find(a[5:4], a[11:6]);
        if (w >= 0) md[a[5:4]][w] = 1;
    endtask

    function automatic logic [AW-1:0] ad(int t, int s, int off);
        return {6'(t), 2'(s), 4'(off)};
    endfunction

    initial begin
        int seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // reset state
        check_all("R8");
        check("R9", busy, 0);

        // R4: lock miss fills, hit only sets lock
        issue(3, 0, ad(1, 2, 7), 0);
        check_all("R4");
        check("R4", last_rd, ad(1, 2, 0));
        issue(3, 0, ad(1, 2, 3), 0);
        check_all("R4");

        // R2: writeback of dirty line, address check
        mark(ad(1, 2, 9));
        issue(1, 0, ad(1, 2, 0), 0);
        check_all("R2");
        check("R2", last_wr, ad(1, 2, 0));

        // R1: locked line survives invalidate
        issue(0, 0, ad(1, 2, 0), 0);
        check_all("R1");
        // R3: locked dirty line written back, stays valid
        mark(ad(1, 2, 0));
        issue(2, 0, ad(1, 2, 0), 0);
        check_all("R3");

        // R6: fill other way, then a third tag finds all ways locked
        issue(3, 0, ad(2, 2, 0), 0);
        issue(3, 0, ad(3, 2, 0), 0);
        check_all("R6");

        // R7: unlock, then unlock again leaves line unchanged
        issue(4, 0, ad(2, 2, 0), 0);
        mark(ad(2, 2, 0));
        issue(4, 0, ad(2, 2, 0), 0);
        check_all("R7");

        // R5: dirty unlocked victim written back before fill
        issue(3, 0, ad(3, 2, 0), 0);
        check_all("R5");
        check("R5", last_wr, ad(2, 2, 0));

        // R11: indexed invalidate of way 1 in set 2 after unlocking
        issue(4, 1, ad(0, 2, 0), 1);
        issue(0, 1, ad(0, 2, 0), 1);
        check_all("R11");

        // R9: command while busy is ignored; sync_done tracks idle
        mark(ad(1, 2, 0));
        @(negedge clk);
        cmd_valid = 1; cmd_op = 3'd1; cmd_indexed = 0; cmd_addr = ad(1, 2, 0);
        @(negedge clk);
        cmd_op = 3'd4; sync_req = 1;
        @(negedge clk);
        check("R9 busy", busy, 1);
        check("R9 sync", sync_done, 0);
        cmd_valid = 0;
        while (busy) @(negedge clk);
        check("R9 sync", sync_done, 1);
        sync_req = 0;
        @(negedge clk);
        model_cmd(1, 0, ad(1, 2, 0), 0);
        check_all("R9");

        // R8: reset clears locked and dirty lines without traffic
        mark(ad(3, 2, 0));
        issue(5, 0, 0, 0);
        check_all("R8");

        // constrained random mix
        for (int n = 0; n < 300; n++) begin
            int op = $urandom % 7;
            logic [AW-1:0] a = ad($urandom % 4, $urandom % 4, $urandom % 16);
            if (op == 6) mark(a);
            else begin
                bit idx = (op != 3) && ($urandom % 3 == 0);
                if (op == 5 && ($urandom % 4 != 0)) op = 3;
                issue(op, idx, a, $urandom % 2);
                check_all(req_of(op));
            end
        end

        // R12: no-writeback variant
        @(negedge clk);
        i_cv = 1; i_op = 3'd3; i_addr = ad(1, 1, 0);
        @(negedge clk); i_cv = 0;
        while (i_busy) @(negedge clk);
        i_mv = 1;
        @(negedge clk); i_mv = 0;
        check("R12 dirty", i_dirty, 0);
        i_cv = 1; i_op = 3'd1;
        @(negedge clk); i_cv = 0;
        while (i_busy) @(negedge clk);
        check("R12 hit", i_hit, 1);
        check("R12 wr", i_wr_seen, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule